// File: doc/BRIEF.md
# Serial Port Control and Interrupt Flags

This block is the register-side control for an asynchronous serial port. It has an 8-bit control register and a status register with five event flags: transmit buffer empty, receive data full, and three receive errors (overrun, framing, parity). It also drives the three interrupt requests of the port. The shifter datapath sends single-cycle pulses when a byte moves between a buffer register and a shift register, and when a receive error is found. The block sets the matching flags from those pulses. In return it gives the shifter a one-cycle start strobe for transmission.

Software can clear a flag only through a fixed sequence. It must first read the status register and see the flag as 1, and then, on the next status write, write a 0 to that bit. A write of 0 without the read first, or a write of 1, leaves the flag as it was. While transmission is disabled, the transmit-empty flag is held at 1. One receive enable bit gates both the receive-full request and the receive-error request.

A low-power entry input clears the control register in the same way reset does. This lets the surrounding chip drop the port into its idle state without a full reset.

Top module: `serial_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x80 (only transmit-empty set), and irq_tx, irq_rx, irq_err and tx_start are all 0.
- R2: The control register is selected by reg_sel=0. It can be written and read back at any time. Bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable, bit 5 the transmit enable, and bits 4..0 are plain storage that read back as written.
- R3: A cycle with doze=1 clears the control register to 0x00 at that clock edge.
- R4: While the transmit enable bit is 0, the transmit-empty flag (status bit 7) stays at 1, including after a legal clear sequence.
- R5: The status register is selected by reg_sel=1. Bit 7 is transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 framing, bit 3 parity, and bits 2..0 read 0. The pulses tx_moved, rx_moved, err_overrun, err_frame and err_parity each set their own flag at the clock edge.
- R6: A flag clears only when two things happen in order. First, a status read (reg_rd=1) returns the flag as 1. Second, the next status write carries 0 in that bit. Each status write ends every pending read-as-one mark. A write of 0 with no such read first, or a write of 1, leaves the flag unchanged.
- R7: If a flag's set pulse arrives in the same cycle as a legal clear of that flag, the flag stays at 1.
- R8: irq_tx is 1 exactly when the transmit interrupt enable and the transmit-empty flag are both 1. Clearing either one removes it.
- R9: irq_rx follows receive-full, and irq_err follows any of the three error flags. Both requests are gated by the receive interrupt enable bit.
- R10: tx_start is 1 for exactly one cycle, in the cycle after a status write that legally clears the transmit-empty flag while transmission is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| doze | input | 1 | Low-power entry; clears the control register |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_rd | input | 1 | Read strobe; on status it marks flags seen as 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tx_moved | input | 1 | Pulse: transmit byte moved from buffer to shift register |
| rx_moved | input | 1 | Pulse: received byte moved from shift register to data register |
| err_overrun | input | 1 | Pulse: receive overrun |
| err_frame | input | 1 | Pulse: framing error |
| err_parity | input | 1 | Pulse: parity error |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| tx_start | output | 1 | One-cycle strobe that starts a transmission |

## Verification
A datapath set pulse and a software clear can fall in the same cycle. The bench provokes this by first arming a flag with a status read. It then issues the clearing status write together with rx_moved for the receive-full flag, and together with tx_moved for the transmit-empty flag. It judges the outcome from the status readback, which must still show the flag as 1. For the transmit-empty case it also checks that tx_start stays 0. It then confirms that the read-as-one mark was used up: a second write of 0 with no read first leaves the flag set.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 5;
    localparam int STAT_BASE = 3;

    // flag indices; status bit = STAT_BASE + index
    localparam int IDX_PER = 0;
    localparam int IDX_FER = 1;
    localparam int IDX_ORE = 2;
    localparam int IDX_RXF = 3;
    localparam int IDX_TXE = 4;

    localparam int CTRL_TE = 5;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic       tx_irq_en;
        logic       rx_irq_en;
        logic       tx_en;
        logic [4:0] spare;
    } ctrl_t;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    function automatic logic [REG_W-1:0] pack_status(flag_vec_t f);
        logic [REG_W-1:0] r;
        r = '0;
        r[STAT_BASE +: NUM_FLAGS] = f;
        return r;
    endfunction

endpackage

// File: rtl/sci_ctrl_reg.sv
module sci_ctrl_reg
    import sci_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         doze,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output ctrl_t        q
);

    always_ff @(posedge clk) begin
        if (rst || doze) begin
            q <= '0;
        end else if (wr_en) begin
            q <= ctrl_t'(wdata);
        end
    end

endmodule

// File: rtl/sci_flag_cell.sv
module sci_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic force_one,
    input  logic set_pulse,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic q,
    output logic armed,
    output logic clr_done
);

    logic clear_ok;

    assign clear_ok = wr_hit && armed && !wr_bit;
    assign clr_done = clear_ok && q && !set_pulse && !force_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (wr_hit) begin
            armed <= 1'b0;
        end else if (rd_hit && q) begin
            armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (force_one || set_pulse) begin
            q <= 1'b1;
        end else if (clear_ok) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/sci_irq_gen.sv
module sci_irq_gen
    import sci_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tx_irq_en,
    input  logic      rx_irq_en,
    input  logic      tx_en,
    input  flag_vec_t flags,
    input  logic      txe_cleared,
    output logic      irq_tx,
    output logic      irq_rx,
    output logic      irq_err,
    output logic      tx_start
);

    logic any_err;

    assign any_err = flags[IDX_PER] | flags[IDX_FER] | flags[IDX_ORE];
    assign irq_tx  = tx_irq_en & flags[IDX_TXE];
    assign irq_rx  = rx_irq_en & flags[IDX_RXF];
    assign irq_err = rx_irq_en & any_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_start <= 1'b0;
        end else begin
            tx_start <= tx_en & txe_cleared;
        end
    end

endmodule

// File: rtl/serial_irq_ctrl.sv
module serial_irq_ctrl
    import sci_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             doze,
    input  logic             reg_sel,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tx_moved,
    input  logic             rx_moved,
    input  logic             err_overrun,
    input  logic             err_frame,
    input  logic             err_parity,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_err,
    output logic             tx_start
);

    ctrl_t     ctrl_q;
    flag_vec_t flag_q;
    flag_vec_t armed_q;
    flag_vec_t clr_vec;
    flag_vec_t set_vec;
    flag_vec_t force_vec;
    logic      stat_rd;
    logic      stat_wr;
    logic      ctrl_wr;
    reg_sel_e  sel;

    assign sel     = reg_sel_e'(reg_sel);
    assign stat_rd = reg_rd && (sel == SEL_STAT);
    assign stat_wr = reg_wr && (sel == SEL_STAT);
    assign ctrl_wr = reg_wr && (sel == SEL_CTRL);

    assign set_vec[IDX_PER] = err_parity;
    assign set_vec[IDX_FER] = err_frame;
    assign set_vec[IDX_ORE] = err_overrun;
    assign set_vec[IDX_RXF] = rx_moved;
    assign set_vec[IDX_TXE] = tx_moved;

    sci_ctrl_reg #(.W(REG_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .doze  (doze),
        .wr_en (ctrl_wr),
        .wdata (reg_wdata),
        .q     (ctrl_q)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        if (i == IDX_TXE) begin : g_held
            assign force_vec[i] = ~ctrl_q.tx_en;
        end else begin : g_free
            assign force_vec[i] = 1'b0;
        end

        sci_flag_cell #(
            .RST_VAL((i == IDX_TXE) ? 1'b1 : 1'b0)
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .force_one (force_vec[i]),
            .set_pulse (set_vec[i]),
            .rd_hit    (stat_rd),
            .wr_hit    (stat_wr),
            .wr_bit    (reg_wdata[STAT_BASE + i]),
            .q         (flag_q[i]),
            .armed     (armed_q[i]),
            .clr_done  (clr_vec[i])
        );
    end

    assign reg_rdata = (sel == SEL_STAT) ? pack_status(flag_q) : REG_W'(ctrl_q);

    sci_irq_gen u_irq (
        .clk         (clk),
        .rst         (rst),
        .tx_irq_en   (ctrl_q.tx_irq_en),
        .rx_irq_en   (ctrl_q.rx_irq_en),
        .tx_en       (ctrl_q.tx_en),
        .flags       (flag_q),
        .txe_cleared (clr_vec[IDX_TXE]),
        .irq_tx      (irq_tx),
        .irq_rx      (irq_rx),
        .irq_err     (irq_err),
        .tx_start    (tx_start)
    );

endmodule

// File: rtl/serial_irq_ctrl_chk.sv
module serial_irq_ctrl_chk
    import sci_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             doze,
    input logic [REG_W-1:0] ctrl_bits,
    input logic             stat_wr,
    input logic             armed_rx,
    input logic             set_rx,
    input logic             set_tx,
    input logic             flag_rx,
    input logic             flag_tx,
    input logic             tx_start
);

    // R3
    doze_clear_chk: assert property (@(posedge clk) disable iff (rst)
        doze |=> (ctrl_bits == '0));

    // R4
    txe_held_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_bits[CTRL_TE] |=> flag_tx);

    // R6
    no_arm_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !armed_rx && !set_rx) |=> $stable(flag_rx));

    // R7
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_rx |=> flag_rx);

    // R7
    tx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_tx |=> flag_tx);

    // R10
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> ($past(ctrl_bits[CTRL_TE]) && !flag_tx));

    // R10
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

endmodule

bind serial_irq_ctrl serial_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .doze      (doze),
    .ctrl_bits (ctrl_q),
    .stat_wr   (stat_wr),
    .armed_rx  (armed_q[sci_irq_pkg::IDX_RXF]),
    .set_rx    (set_vec[sci_irq_pkg::IDX_RXF]),
    .set_tx    (set_vec[sci_irq_pkg::IDX_TXE]),
    .flag_rx   (flag_q[sci_irq_pkg::IDX_RXF]),
    .flag_tx   (flag_q[sci_irq_pkg::IDX_TXE]),
    .tx_start  (tx_start)
);

// File: tb/test_serial_irq_ctrl.sv
module test_serial_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       doze = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_moved = 1'b0;
    logic       rx_moved = 1'b0;
    logic       err_overrun = 1'b0;
    logic       err_frame = 1'b0;
    logic       err_parity = 1'b0;
    logic       irq_tx, irq_rx, irq_err, tx_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    string       tag_q[$];
    logic [11:0] exp_q[$];
    event        obs_ev;

    // event pulse encoding: {tx_moved, rx_moved, err_overrun, err_frame, err_parity}
    localparam logic [4:0] EV_NONE = 5'b00000;
    localparam logic [4:0] EV_TX   = 5'b10000;
    localparam logic [4:0] EV_RX   = 5'b01000;
    localparam logic [4:0] EV_ORE  = 5'b00100;
    localparam logic [4:0] EV_FER  = 5'b00010;
    localparam logic [4:0] EV_PER  = 5'b00001;

    always #5 clk = ~clk;

    serial_irq_ctrl i_serial_irq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .doze        (doze),
        .reg_sel     (reg_sel),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .tx_moved    (tx_moved),
        .rx_moved    (rx_moved),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .irq_tx      (irq_tx),
        .irq_rx      (irq_rx),
        .irq_err     (irq_err),
        .tx_start    (tx_start)
    );

    // monitor: pops one expected item per request, compares at the falling edge
    initial begin
        forever begin
            @(obs_ev);
            @(negedge clk);
            begin
                string       t;
                logic [11:0] e;
                logic [11:0] got;
                t   = tag_q.pop_front();
                e   = exp_q.pop_front();
                got = {reg_rdata, irq_tx, irq_rx, irq_err, tx_start};
                n_checks++;
                if (got !== e) begin
                    n_fail++;
                    $display("FAIL %s: got rdata=%h tx/rx/err/start=%b expected rdata=%h tx/rx/err/start=%b",
                             t, got[11:4], got[3:0], e[11:4], e[3:0]);
                end
            end
        end
    end

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ev(input logic [4:0] ev);
        {tx_moved, rx_moved, err_overrun, err_frame, err_parity} = ev;
    endtask

    task automatic wr(input logic sel, input logic [7:0] data, input logic [4:0] ev);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1; set_ev(ev);
        cycle();
        reg_wr = 1'b0; set_ev(EV_NONE);
    endtask

    task automatic rd_status();
        reg_sel = 1'b1; reg_rd = 1'b1;
        cycle();
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] ev);
        set_ev(ev);
        cycle();
        set_ev(EV_NONE);
    endtask

    // driver: queues the expected outputs, then lets the monitor sample
    task automatic expect_obs(input string tag, input logic sel, input logic [7:0] rdat,
                              input logic it, input logic ir, input logic ie, input logic ts);
        reg_sel = sel;
        tag_q.push_back(tag);
        exp_q.push_back({rdat, it, ir, ie, ts});
        -> obs_ev;
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();
        rst = 1'b0;
        cycle();

        // R1 reset state
        expect_obs("R1 ctrl after reset", 1'b0, 8'h00, 0, 0, 0, 0);
        expect_obs("R1 status after reset", 1'b1, 8'h80, 0, 0, 0, 0);

        // R2 readback incl. storage bits
        wr(1'b0, 8'h1F, EV_NONE);
        expect_obs("R2 ctrl readback 1F", 1'b0, 8'h1F, 0, 0, 0, 0);
        wr(1'b0, 8'h15, EV_NONE);
        expect_obs("R2 ctrl readback 15", 1'b0, 8'h15, 0, 0, 0, 0);

        // R8 transmit request with enable, transmit disabled
        wr(1'b0, 8'h80, EV_NONE);
        expect_obs("R8 irq_tx on", 1'b1, 8'h80, 1, 0, 0, 0);

        // R4 legal clear while transmit disabled has no effect
        rd_status();
        wr(1'b1, 8'h00, EV_NONE);
        expect_obs("R4 txe held while disabled", 1'b1, 8'h80, 1, 0, 0, 0);

        // R6 clear without prior read, and write of 1
        wr(1'b0, 8'hA0, EV_NONE);
        wr(1'b1, 8'h00, EV_NONE);
        expect_obs("R6 write 0 without read", 1'b1, 8'h80, 1, 0, 0, 0);
        rd_status();
        wr(1'b1, 8'hFF, EV_NONE);
        expect_obs("R6 write 1 no effect", 1'b1, 8'h80, 1, 0, 0, 0);

        // R10 legal clear starts transmission
        rd_status();
        wr(1'b1, 8'h00, EV_NONE);
        expect_obs("R10 tx_start pulse, R8 irq_tx off", 1'b1, 8'h00, 0, 0, 0, 1);
        expect_obs("R10 tx_start single cycle", 1'b1, 8'h00, 0, 0, 0, 0);

        // R5 transmit-moved pulse sets flag
        pulse(EV_TX);
        expect_obs("R5 tx_moved sets txe", 1'b1, 8'h80, 1, 0, 0, 0);
        // R8 clearing enable removes request
        wr(1'b0, 8'h20, EV_NONE);
        expect_obs("R8 irq_tx off by enable", 1'b1, 8'h80, 0, 0, 0, 0);

        // R9 receive gating
        pulse(EV_RX);
        expect_obs("R9 irq_rx gated off", 1'b1, 8'hC0, 0, 0, 0, 0);
        wr(1'b0, 8'h60, EV_NONE);
        expect_obs("R9 irq_rx on", 1'b1, 8'hC0, 0, 1, 0, 0);
        pulse(EV_FER);
        expect_obs("R5 framing sets, R9 irq_err", 1'b1, 8'hD0, 0, 1, 1, 0);
        pulse(EV_PER | EV_ORE);
        expect_obs("R5 parity and overrun set", 1'b1, 8'hF8, 0, 1, 1, 0);

        // R6 selective clear of framing only
        rd_status();
        wr(1'b1, 8'hEF, EV_NONE);
        expect_obs("R6 framing cleared alone", 1'b1, 8'hE8, 0, 1, 1, 0);
        rd_status();
        wr(1'b1, 8'hC7, EV_NONE);
        expect_obs("R9 irq_err drops with errors", 1'b1, 8'hC0, 0, 1, 0, 0);

        // R7 set wins over legal clear (receive-full)
        rd_status();
        wr(1'b1, 8'hBF, EV_RX);
        expect_obs("R7 rx set beats clear", 1'b1, 8'hC0, 0, 1, 0, 0);
        wr(1'b1, 8'hBF, EV_NONE);
        expect_obs("R6 mark consumed by write", 1'b1, 8'hC0, 0, 1, 0, 0);
        rd_status();
        wr(1'b1, 8'hBF, EV_NONE);
        expect_obs("R6 rx legal clear", 1'b1, 8'h80, 0, 0, 0, 0);

        // R7 set wins over legal clear (transmit-empty), no start strobe
        rd_status();
        wr(1'b1, 8'h7F, EV_TX);
        expect_obs("R7 tx set beats clear", 1'b1, 8'h80, 0, 0, 0, 0);

        // R9 error request gated by receive enable
        wr(1'b0, 8'h20, EV_NONE);
        pulse(EV_ORE);
        expect_obs("R9 irq_err gated off", 1'b1, 8'hA0, 0, 0, 0, 0);
        wr(1'b0, 8'h60, EV_NONE);
        expect_obs("R9 irq_err on", 1'b1, 8'hA0, 0, 0, 1, 0);

        // R3 doze clears control; R4 txe forced back to 1
        rd_status();
        wr(1'b1, 8'h7F, EV_NONE);
        expect_obs("R10 second start pulse", 1'b1, 8'h20, 0, 0, 1, 1);
        doze = 1'b1;
        cycle();
        doze = 1'b0;
        cycle();
        expect_obs("R3 ctrl cleared by doze", 1'b0, 8'h00, 0, 0, 0, 0);
        expect_obs("R4 txe forced after disable", 1'b1, 8'hA0, 0, 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule